// File: doc/BRIEF.md
# Forward-error-correction ratio divider network

This block is the bypass and test path of a clock generator that scales a reference by 14/15, 15/14, 14/14 or 15/15 for forward-error-correction links. Everything runs synchronously on the reference clock. A prescale divider of length N (14 or 15) feeds a second divider of length M (15 or 14). A small post-divider turns the N-rate tick into /2N and /4N phases. The two clock outputs and a single test output are then chosen from these results through a routing table. The table is keyed on a two-bit output-divide code and a test-select bit.

The selects are static configuration. They are captured only while the synchronous active-low master reset is held, and every counter restarts from zero when reset is released. The outputs are not required to have a 50% duty cycle. Each output rises exactly once per period, or twice per base length where the rate calls for half a divider length. A path-select input stands in for the analog loop, which is not modelled: when it selects the loop, the divider network idles and all three outputs stay low.

Top module: `fec_ratio_divnet`

## Requirements
- R1: `n_sel` = 0 gives N = 14 and `n_sel` = 1 gives N = 15.
- R2: `m_sel` = 0 gives M = 15 and `m_sel` = 1 gives M = 14.
- R3: `fout0` has a period of 4N reference cycles for `odiv_sel` = 2'b00, and N cycles for 2'b01, 2'b10 and 2'b11.
- R4: `fout1` has a period of N reference cycles for `odiv_sel` = 2'b00 and 2'b01, 2N for 2'b10, and 4N for 2'b11.
- R5: With `test_en` = 1 and `test_sel` = 0, `test_out` makes two rising edges every N cycles for codes 2'b00 and 2'b01, and one every N cycles for codes 2'b10 and 2'b11. For odd N, the two periods are floor(N/2) and ceil(N/2) cycles.
- R6: With `test_en` = 1 and `test_sel` = 1, `test_out` has a period of 2MN cycles for code 2'b00. For code 2'b01 it makes two rising edges every MN cycles. For codes 2'b10 and 2'b11 the period is MN cycles.
- R7: While `test_en` = 0, `test_out` stays low, and `fout0` and `fout1` follow R3 and R4 unchanged.
- R8: A clock edge that samples `rst_n` = 0 clears all counters and drives `fout0`, `fout1` and `test_out` low after that edge.
- R9: All selects (`n_sel`, `m_sel`, `odiv_sel`, `test_en`, `test_sel`, `pll_sel`) are captured only on edges where `rst_n` = 0. Changes while out of reset have no effect until the next reset.
- R10: When `pll_sel` = 1 is captured, the divider network idles and all three outputs stay low.
- R11: Counting restarts at zero. On the first edge after reset release, every output driven by the network rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low master reset; also the capture window for the selects |
| n_sel | input | 1 | N divide select |
| m_sel | input | 1 | M divide select |
| odiv_sel | input | 2 | Output-divide code, keys the routing table |
| test_en | input | 1 | Enables the test output |
| test_sel | input | 1 | Test output source: 0 N-based, 1 MN-based |
| pll_sel | input | 1 | 1 selects the unmodelled loop path; the network idles |
| fout0 | output | 1 | First divided clock |
| fout1 | output | 1 | Second divided clock |
| test_out | output | 1 | Test output carrying intermediate division results |

## Verification
On every cycle, the assertions check several things. The N and M counters stay below their selected lengths, and the M counter advances only on an N wrap. The captured configuration does not move outside reset. Every counter is zero on the first cycle after reset is released. All outputs are low after a reset edge, the test output is quiet while it is disabled, and everything is quiet while the loop path is selected. The frequency ratios themselves can only be shown by the directed scenarios. These count rising edges over a window of 8·M·N cycles for every combination of N, M, output code and test select. The scenarios also show that selects changed outside reset are ignored, and that the half-length rates stay exact for odd N and for odd MN.

// File: rtl/fec_div_pkg.sv
// Package: shared configuration types and divide-value defaults for the
// forward-error-correction ratio divider network.
package fec_div_pkg;

    // Output-divide code; the encoding keys the routing table.
    typedef enum logic [1:0] {
        ODIV_F0_SLOW  = 2'b00,
        ODIV_EQUAL    = 2'b01,
        ODIV_F1_HALF  = 2'b10,
        ODIV_F1_QUART = 2'b11
    } odiv_e;

    // Static configuration, captured during master reset.
    typedef struct packed {
        logic  n_hi;
        logic  m_hi;
        odiv_e odiv;
        logic  tsel;
        logic  ten;
        logic  loop_path;
    } cfg_t;

    localparam int unsigned DEF_N_SEL0 = 14;
    localparam int unsigned DEF_N_SEL1 = 15;
    localparam int unsigned DEF_M_SEL0 = 15;
    localparam int unsigned DEF_M_SEL1 = 14;

endpackage

// File: rtl/fec_cfg_hold.sv
// Module: fec_cfg_hold
// Captures the static configuration on every clock edge that samples the
// master reset low, and freezes it otherwise.
// Assumes: selects are static while reset is held for at least one edge.
module fec_cfg_hold
    import fec_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cfg_t cfg_in,
    output cfg_t cfg_q
);

    // Configuration register: loads only during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= cfg_in;
        end
    end

    // R9: configuration frozen outside reset
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(cfg_q))
        else $error("configuration moved outside reset");

endmodule

// File: rtl/fec_ratio_counters.sv
// Module: fec_ratio_counters
// N prescaler, M divider (advanced on each N wrap), a two-bit post-divider
// of N wraps, and a toggle flip on each M wrap. All are cleared by the
// synchronous active-low reset and frozen while run is low.
// Assumes: n_len >= 2 and m_len >= 2, both constant outside reset.
module fec_ratio_counters #(
    parameter int unsigned CW = 4,
    parameter int unsigned MW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] n_len,
    input  logic [MW-1:0] m_len,
    output logic [CW-1:0] n_cnt,
    output logic [MW-1:0] m_cnt,
    output logic [1:0]    quad,
    output logic          sup
);

    localparam logic [CW-1:0] N_ONE = 1;
    localparam logic [MW-1:0] M_ONE = 1;

    logic n_wrap;
    logic m_wrap;

    // Wrap detection for the two chained dividers.
    always_comb begin
        n_wrap = (n_cnt == n_len - N_ONE);
        m_wrap = n_wrap && (m_cnt == m_len - M_ONE);
    end

    // Counter chain: N prescaler, then M divider, post-divider and toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_cnt <= '0;
            m_cnt <= '0;
            quad  <= 2'b00;
            sup   <= 1'b0;
        end else if (run) begin
            n_cnt <= n_wrap ? '0 : n_cnt + N_ONE;
            if (n_wrap) begin
                quad  <= quad + 2'b01;
                m_cnt <= m_wrap ? '0 : m_cnt + M_ONE;
                if (m_wrap) begin
                    sup <= ~sup;
                end
            end
        end
    end

    // R1: N counter stays inside the selected length
    p_ncnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        n_cnt < n_len)
        else $error("N counter out of range");

    // R2: M counter stays inside the selected length
    p_mcnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        m_cnt < m_len)
        else $error("M counter out of range");

    // R2: M counter only moves on an N wrap
    p_mcnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !n_wrap |=> $stable(m_cnt))
        else $error("M counter moved without N wrap");

    // R11: everything restarts from zero at reset release
    p_restart_r11: assert property (@(posedge clk)
        $rose(rst_n) |-> (n_cnt == '0 && m_cnt == '0 && quad == 2'b00 && !sup))
        else $error("counters not zero at reset release");

endmodule

// File: rtl/fec_out_router.sv
// Module: fec_out_router
// Forms clock levels from the counter state and routes them to the two
// clock outputs and the test output by the output code and test select.
// Outputs are registered; each rises at position zero of its period.
// Assumes: lengths of at least 4 so that every high phase is non-empty.
module fec_out_router
    import fec_div_pkg::*;
#(
    parameter int unsigned CW = 4,
    parameter int unsigned MW = 4,
    parameter int unsigned PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  odiv_e         odiv,
    input  logic          tsel,
    input  logic          ten,
    input  logic [CW-1:0] n_len,
    input  logic [MW-1:0] m_len,
    input  logic [CW-1:0] n_cnt,
    input  logic [MW-1:0] m_cnt,
    input  logic [1:0]    quad,
    input  logic          sup,
    output logic          fout0,
    output logic          fout1,
    output logic          test_out
);

    logic [CW:0] n_half, n_qtr, n_pos;
    logic [PW:0] mn_len, mn_half, mn_qtr, mn_pos;
    logic lvl_n, lvl_2n, lvl_4n, lvl_n2;
    logic lvl_mn, lvl_2mn, lvl_mn2;
    logic f0_d, f1_d, t_d;

    // Clock levels within the N-based lengths.
    always_comb begin
        n_pos  = {1'b0, n_cnt};
        n_half = {1'b0, n_len} >> 1;
        n_qtr  = {1'b0, n_len} >> 2;
        lvl_n  = n_pos < n_half;
        lvl_2n = !quad[0];
        lvl_4n = !quad[1];
        lvl_n2 = (n_pos < n_qtr) || ((n_pos >= n_half) && (n_pos < n_half + n_qtr));
    end

    // Clock levels within the MN-based lengths.
    always_comb begin
        mn_len  = (PW + 1)'(m_len) * (PW + 1)'(n_len);
        mn_pos  = (PW + 1)'(m_cnt) * (PW + 1)'(n_len) + (PW + 1)'(n_cnt);
        mn_half = mn_len >> 1;
        mn_qtr  = mn_len >> 2;
        lvl_mn  = m_cnt < (m_len >> 1);
        lvl_2mn = !sup;
        lvl_mn2 = (mn_pos < mn_qtr) || ((mn_pos >= mn_half) && (mn_pos < mn_half + mn_qtr));
    end

    // Routing table keyed on the output code and the test select.
    always_comb begin
        case (odiv)
            ODIV_F0_SLOW: begin
                f0_d = lvl_4n;
                f1_d = lvl_n;
                t_d  = tsel ? lvl_2mn : lvl_n2;
            end
            ODIV_EQUAL: begin
                f0_d = lvl_n;
                f1_d = lvl_n;
                t_d  = tsel ? lvl_mn2 : lvl_n2;
            end
            ODIV_F1_HALF: begin
                f0_d = lvl_n;
                f1_d = lvl_2n;
                t_d  = tsel ? lvl_mn : lvl_n;
            end
            default: begin
                f0_d = lvl_n;
                f1_d = lvl_4n;
                t_d  = tsel ? lvl_mn : lvl_n;
            end
        endcase
    end

    // Output registers: low in reset, low while idle, test gated by enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fout0    <= 1'b0;
            fout1    <= 1'b0;
            test_out <= 1'b0;
        end else begin
            fout0    <= run && f0_d;
            fout1    <= run && f1_d;
            test_out <= run && ten && t_d;
        end
    end

    // R8: a reset edge leaves every output low
    p_reset_low_r8: assert property (@(posedge clk)
        !rst_n |=> (!fout0 && !fout1 && !test_out))
        else $error("outputs not low after reset edge");

    // R7: disabled test output stays quiet
    p_test_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ten |-> !test_out)
        else $error("test output active while disabled");

    // R10: idle network keeps all outputs low
    p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!fout0 && !fout1 && !test_out))
        else $error("output active while loop path selected");

endmodule

// File: rtl/fec_ratio_divnet.sv
// Module: fec_ratio_divnet (top)
// Bypass and test divider network of a forward-error-correction ratio clock
// generator. Captures the selects during reset, runs the N/M counter chain
// on the reference clock and routes divided levels to three outputs.
// Assumes: rst_n is synchronous to clk and held low for at least one edge.
module fec_ratio_divnet
    import fec_div_pkg::*;
#(
    parameter int unsigned N_SEL0 = DEF_N_SEL0,
    parameter int unsigned N_SEL1 = DEF_N_SEL1,
    parameter int unsigned M_SEL0 = DEF_M_SEL0,
    parameter int unsigned M_SEL1 = DEF_M_SEL1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       n_sel,
    input  logic       m_sel,
    input  logic [1:0] odiv_sel,
    input  logic       test_en,
    input  logic       test_sel,
    input  logic       pll_sel,
    output logic       fout0,
    output logic       fout1,
    output logic       test_out
);

    localparam int unsigned N_MAX = (N_SEL0 > N_SEL1) ? N_SEL0 : N_SEL1;
    localparam int unsigned M_MAX = (M_SEL0 > M_SEL1) ? M_SEL0 : M_SEL1;
    localparam int unsigned CW    = $clog2(N_MAX + 1);
    localparam int unsigned MW    = $clog2(M_MAX + 1);
    localparam int unsigned PW    = $clog2(N_MAX * M_MAX + 1);

    cfg_t          cfg_in, cfg;
    logic [CW-1:0] n_len, n_cnt;
    logic [MW-1:0] m_len, m_cnt;
    logic [1:0]    quad;
    logic          sup;
    logic          run;

    // Pack the select pins into one configuration word.
    always_comb begin
        cfg_in.n_hi      = n_sel;
        cfg_in.m_hi      = m_sel;
        cfg_in.odiv      = odiv_e'(odiv_sel);
        cfg_in.tsel      = test_sel;
        cfg_in.ten       = test_en;
        cfg_in.loop_path = pll_sel;
    end

    // Decode captured selects into divide lengths and the run flag.
    always_comb begin
        n_len = cfg.n_hi ? CW'(N_SEL1) : CW'(N_SEL0);
        m_len = cfg.m_hi ? MW'(M_SEL1) : MW'(M_SEL0);
        run   = !cfg.loop_path;
    end

    fec_cfg_hold u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_in (cfg_in),
        .cfg_q  (cfg)
    );

    fec_ratio_counters #(.CW(CW), .MW(MW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .n_len (n_len),
        .m_len (m_len),
        .n_cnt (n_cnt),
        .m_cnt (m_cnt),
        .quad  (quad),
        .sup   (sup)
    );

    fec_out_router #(.CW(CW), .MW(MW), .PW(PW)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .odiv     (cfg.odiv),
        .tsel     (cfg.tsel),
        .ten      (cfg.ten),
        .n_len    (n_len),
        .m_len    (m_len),
        .n_cnt    (n_cnt),
        .m_cnt    (m_cnt),
        .quad     (quad),
        .sup      (sup),
        .fout0    (fout0),
        .fout1    (fout1),
        .test_out (test_out)
    );

endmodule

// File: tb/sim_fec_ratio_divnet.sv
// Directed bench: counts rising edges of each output over 8*M*N reference
// cycles after reset release and compares them with the ratios required.
module sim_fec_ratio_divnet;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic n_sel = 1'b0, m_sel = 1'b0, test_en = 1'b0, test_sel = 1'b0, pll_sel = 1'b0;
    logic [1:0] odiv_sel = 2'b00;
    logic fout0, fout1, test_out;

    int errors = 0;
    int checks = 0;
    logic first_f0, first_f1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fec_ratio_divnet u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .n_sel    (n_sel),
        .m_sel    (m_sel),
        .odiv_sel (odiv_sel),
        .test_en  (test_en),
        .test_sel (test_sel),
        .pll_sel  (pll_sel),
        .fout0    (fout0),
        .fout1    (fout1),
        .test_out (test_out)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Hold reset for three edges with the given selects, release at negedge.
    task automatic config_reset(input logic ns, input logic ms, input logic [1:0] od,
                                input logic te, input logic ts, input logic ps);
        @(negedge clk);
        rst_n = 1'b0; n_sel = ns; m_sel = ms; odiv_sel = od;
        test_en = te; test_sel = ts; pll_sel = ps;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Count rising edges over w cycles, sampling 1 time unit after each edge.
    task automatic measure(input int w, output int c0, output int c1, output int ct);
        logic p0 = 1'b0, p1 = 1'b0, pt = 1'b0;
        c0 = 0; c1 = 0; ct = 0;
        for (int k = 0; k < w; k++) begin
            @(posedge clk);
            #1;
            if (k == 0) begin
                first_f0 = fout0;
                first_f1 = fout1;
            end
            if (fout0 && !p0) c0++;
            if (fout1 && !p1) c1++;
            if (test_out && !pt) ct++;
            p0 = fout0; p1 = fout1; pt = test_out;
        end
    endtask

    function automatic int n_of(input logic s);
        return s ? 15 : 14;   // R1 encoding
    endfunction

    function automatic int m_of(input logic s);
        return s ? 14 : 15;   // R2 encoding
    endfunction

    // R8: outputs low while reset is held, and after a reset edge mid-run.
    task automatic t_reset_state();
        int c0, c1, ct;
        config_reset(1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R8", "outputs during reset", {29'd0, fout0, fout1, test_out}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        measure(20, c0, c1, ct);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R8", "outputs after mid-run reset edge", {29'd0, fout0, fout1, test_out}, 0);
    endtask

    // R1..R6, R11: every N, M, output code and test select combination.
    task automatic t_ratio_sweep();
        for (int ns = 0; ns < 2; ns++)
            for (int ms = 0; ms < 2; ms++)
                for (int od = 0; od < 4; od++)
                    for (int ts = 0; ts < 2; ts++) begin
                        int n = n_of(ns[0]);
                        int m = m_of(ms[0]);
                        int w = 8 * m * n;
                        int e0, e1, et, c0, c1, ct;
                        e0 = (od == 0) ? w / (4 * n) : w / n;
                        e1 = (od < 2) ? w / n : (od == 2) ? w / (2 * n) : w / (4 * n);
                        if (ts == 0) et = (od < 2) ? 2 * w / n : w / n;
                        else et = (od == 0) ? w / (2 * m * n) : (od == 1) ? 2 * w / (m * n) : w / (m * n);
                        config_reset(ns[0], ms[0], od[1:0], 1'b1, ts[0], 1'b0);
                        measure(w, c0, c1, ct);
                        check("R3", $sformatf("fout0 R1/R2 N=%0d M=%0d od=%0d", n, m, od), c0, e0);
                        check("R4", $sformatf("fout1 N=%0d M=%0d od=%0d", n, m, od), c1, e1);
                        check(ts ? "R6" : "R5", $sformatf("test N=%0d M=%0d od=%0d ts=%0d", n, m, od, ts), ct, et);
                        if (ns == 1 && ms == 0 && ts == 0) begin
                            check("R11", $sformatf("fout0 high on first edge od=%0d", od), int'(first_f0), 1);
                            check("R11", $sformatf("fout1 high on first edge od=%0d", od), int'(first_f1), 1);
                        end
                    end
    endtask

    // R7: disabled test output is quiet, clocks unaffected.
    task automatic t_test_disabled();
        int c0, c1, ct;
        config_reset(1'b1, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0);
        measure(8 * 14 * 15, c0, c1, ct);
        check("R7", "test edges while disabled", ct, 0);
        check("R7", "fout0 while test disabled", c0, 8 * 14);
        check("R7", "fout1 while test disabled", c1, 2 * 14);
    endtask

    // R10: loop path selected, network idle.
    task automatic t_loop_idle();
        int c0, c1, ct;
        config_reset(1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 1'b1);
        measure(8 * 15 * 15, c0, c1, ct);
        check("R10", "edges while loop path selected", c0 + c1 + ct, 0);
    endtask

    // R9: select changes outside reset are ignored.
    task automatic t_select_frozen();
        int c0, c1, ct;
        int w = 8 * 14 * 15;
        config_reset(1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0);
        n_sel = 1'b1; m_sel = 1'b1; odiv_sel = 2'b11;
        test_en = 1'b0; test_sel = 1'b1; pll_sel = 1'b1;
        measure(w, c0, c1, ct);
        check("R9", "fout0 after live select change", c0, w / 14);
        check("R9", "fout1 after live select change", c1, w / 14);
        check("R9", "test after live select change", ct, 2 * w / 14);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_ratio_sweep();
        t_test_disabled();
        t_loop_idle();
        t_select_frozen();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule